// File: doc/BRIEF.md
# Three-Port Permutation Table Memory

This block is a small synchronous byte memory that holds the 256-entry permutation table of a byte-oriented stream cipher engine. It has three ports on one clock. The first port only reads. The second port only writes. The third port either reads or writes in a given cycle. A cipher datapath can therefore read one table entry while it swaps two others.

Writes take effect at the clock edge. Reads are registered and return data one clock after they are issued. When a write and a read from a different port hit the same address in the same cycle, the read returns the value being written. The swap of two entries is then visible to the next fetch with no stall. If both write ports target one address at once, the third port wins. The client performs the table initialisation, so the memory contents are undefined until they are written. Reset clears only the two read output registers.

Top module: `sbox_tri_mem`

## Requirements
- R1: The memory holds 256 independently addressable bytes. A value written to an address is returned by every later read of that address until it is overwritten.
- R2: A port-1 read issued with `rd1_en`=1 presents its data on `rd1_data` one clock later. While `rd1_en`=0, `rd1_data` keeps its value.
- R3: A port-3 read, issued with `p3_en`=1 and `p3_we`=0, presents its data on `p3_rdata` one clock later. While `p3_en`=0, `p3_rdata` keeps its value.
- R4: Port 2 and port 3 can write two different addresses in the same cycle, and both values are stored.
- R5: If port 2 and port 3 write the same address in the same cycle, the port-3 data is stored and the port-2 data is discarded. A coverage point records the event.
- R6: A port-1 read of the address that port 2 writes in the same cycle returns the newly written data.
- R7: A port-1 read of the address that port 3 writes in the same cycle returns the newly written data.
- R8: A port-3 read of the address that port 2 writes in the same cycle returns the newly written data.
- R9: When ports 2 and 3 both write the address that port 1 reads in that cycle, port 1 returns the port-3 data.
- R10: A port-3 write (`p3_en`=1, `p3_we`=1) performs no port-3 read, and `p3_rdata` keeps its previous value.
- R11: While `rst_n` is low, `rd1_data` and `p3_rdata` are cleared to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all ports |
| rst_n | input | 1 | Synchronous active-low reset of the read output registers |
| rd1_en | input | 1 | Port-1 read request |
| rd1_addr | input | ADDR_W | Port-1 read address |
| rd1_data | output | DATA_W | Port-1 registered read data |
| wr2_en | input | 1 | Port-2 write request |
| wr2_addr | input | ADDR_W | Port-2 write address |
| wr2_data | input | DATA_W | Port-2 write data |
| p3_en | input | 1 | Port-3 access request |
| p3_we | input | 1 | Port-3 direction: 1 writes, 0 reads |
| p3_addr | input | ADDR_W | Port-3 address |
| p3_wdata | input | DATA_W | Port-3 write data |
| p3_rdata | output | DATA_W | Port-3 registered read data |

## Verification
Every read result is due exactly one clock edge after the cycle that issues it. Every write is visible to a read issued in the same cycle or any later cycle. The bench applies inputs just after a rising edge, holds them across one edge, and compares the outputs just after that edge against a model of the table that it keeps from the requirements. Hold behaviour is checked across several idle edges and during port-3 writes. The reset clear is checked after the outputs have been driven to nonzero values.

// File: rtl/pmem_pkg.sv
// Package: shared types for the three-port permutation table memory.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pmem_pkg;

    // Source that supplies the data of one registered read.
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_WR2   = 2'd1,
        SRC_WR3   = 2'd2
    } fwd_src_e;

endpackage

// File: rtl/pmem_array.sv
// Module: pmem_array
// Storage of 2**ADDR_W words with two write ports and NRD asynchronous
// read taps. When both write ports hit one address, port 3 wins.
// Assumes: the contents have no reset and are undefined until written.
module pmem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NRD    = 2
) (
    input  logic                           clk,
    input  logic                           w2_en,
    input  logic [ADDR_W-1:0]              w2_addr,
    input  logic [DATA_W-1:0]              w2_data,
    input  logic                           w3_en,
    input  logic [ADDR_W-1:0]              w3_addr,
    input  logic [DATA_W-1:0]              w3_data,
    input  logic [NRD-1:0][ADDR_W-1:0]     rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]     rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              w2_blocked;

    // A port-2 write yields to a port-3 write of the same address.
    always_comb w2_blocked = w3_en && (w3_addr == w2_addr);

    // Commit the accepted writes at the clock edge.
    always_ff @(posedge clk) begin
        if (w2_en && !w2_blocked) begin
            mem[w2_addr] <= w2_data;
        end
        if (w3_en) begin
            mem[w3_addr] <= w3_data;
        end
    end

    // One asynchronous read tap per read port.
    for (genvar g = 0; g < NRD; g++) begin : g_tap
        assign rd_data[g] = mem[rd_addr[g]];
    end

endmodule

// File: rtl/pmem_fwd.sv
// Module: pmem_fwd
// Write-first bypass for one read port. It selects the data of a write
// issued in the same cycle to the read address, and otherwise the stored
// word. Port 3 has priority over port 2, matching the array.
// Assumes: arr_data is the stored word at rd_addr before this cycle's writes.
module pmem_fwd
    import pmem_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              w2_en,
    input  logic [ADDR_W-1:0] w2_addr,
    input  logic [DATA_W-1:0] w2_data,
    input  logic              w3_en,
    input  logic [ADDR_W-1:0] w3_addr,
    input  logic [DATA_W-1:0] w3_data,
    output logic [DATA_W-1:0] fwd_data
);
    fwd_src_e src;

    // Pick the source of the read data by address match and priority.
    always_comb begin
        if (w3_en && (w3_addr == rd_addr)) begin
            src = SRC_WR3;
        end else if (w2_en && (w2_addr == rd_addr)) begin
            src = SRC_WR2;
        end else begin
            src = SRC_ARRAY;
        end
    end

    // Drive the data of the selected source.
    always_comb begin
        unique case (src)
            SRC_WR3: fwd_data = w3_data;
            SRC_WR2: fwd_data = w2_data;
            default: fwd_data = arr_data;
        endcase
    end

endmodule

// File: rtl/pmem_rdreg.sv
// Module: pmem_rdreg
// Read output register. It loads when its port issues a read and holds
// otherwise.
// Assumes: synchronous active-low reset that clears the output to zero.
module pmem_rdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Capture the read data, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sbox_tri_mem.sv
// Module: sbox_tri_mem
// Permutation table memory with three ports on one clock: port 1 reads,
// port 2 writes, and port 3 reads or writes. Reads have one cycle of
// latency. Writes issued in the same cycle are forwarded to the reads of
// the other ports (write-first). Port 3 wins a same-address write collision.
// Assumes: the client initialises the contents, and reset clears only the
// read output registers.
module sbox_tri_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd1_en,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr2_en,
    input  logic [ADDR_W-1:0] wr2_addr,
    input  logic [DATA_W-1:0] wr2_data,
    input  logic              p3_en,
    input  logic              p3_we,
    input  logic [ADDR_W-1:0] p3_addr,
    input  logic [DATA_W-1:0] p3_wdata,
    output logic [DATA_W-1:0] p3_rdata
);
    localparam int NRD = 2;

    logic                       p3_wen;
    logic                       p3_ren;
    logic [NRD-1:0]             rd_en_v;
    logic [NRD-1:0][ADDR_W-1:0] rd_addr_v;
    logic [NRD-1:0][DATA_W-1:0] arr_q_v;
    logic [NRD-1:0][DATA_W-1:0] fwd_q_v;
    logic [NRD-1:0][DATA_W-1:0] out_q_v;

    // Split the port-3 request into a write and a read.
    always_comb begin
        p3_wen = p3_en && p3_we;
        p3_ren = p3_en && !p3_we;
    end

    // Gather the read ports: index 0 is port 1, index 1 is port 3.
    always_comb begin
        rd_en_v[0]   = rd1_en;
        rd_addr_v[0] = rd1_addr;
        rd_en_v[1]   = p3_ren;
        rd_addr_v[1] = p3_addr;
    end

    pmem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NRD    (NRD)
    ) array_i (
        .clk     (clk),
        .w2_en   (wr2_en),
        .w2_addr (wr2_addr),
        .w2_data (wr2_data),
        .w3_en   (p3_wen),
        .w3_addr (p3_addr),
        .w3_data (p3_wdata),
        .rd_addr (rd_addr_v),
        .rd_data (arr_q_v)
    );

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        pmem_fwd #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) fwd_i (
            .rd_addr  (rd_addr_v[g]),
            .arr_data (arr_q_v[g]),
            .w2_en    (wr2_en),
            .w2_addr  (wr2_addr),
            .w2_data  (wr2_data),
            .w3_en    (p3_wen),
            .w3_addr  (p3_addr),
            .w3_data  (p3_wdata),
            .fwd_data (fwd_q_v[g])
        );

        pmem_rdreg #(
            .DATA_W (DATA_W)
        ) rdreg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (rd_en_v[g]),
            .d     (fwd_q_v[g]),
            .q     (out_q_v[g])
        );
    end

    // Drive the output ports from the read registers.
    always_comb begin
        rd1_data = out_q_v[0];
        p3_rdata = out_q_v[1];
    end

endmodule

// File: rtl/pmem_chk.sv
// Module: pmem_chk
// Checker for sbox_tri_mem. It observes only the ports and is attached
// with the bind statement at the end of this file.
// Assumes: it is clocked by the memory clock and gated by its reset.
module pmem_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd1_en,
    input logic [ADDR_W-1:0] rd1_addr,
    input logic [DATA_W-1:0] rd1_data,
    input logic              wr2_en,
    input logic [ADDR_W-1:0] wr2_addr,
    input logic [DATA_W-1:0] wr2_data,
    input logic              p3_en,
    input logic              p3_we,
    input logic [ADDR_W-1:0] p3_addr,
    input logic [DATA_W-1:0] p3_wdata,
    input logic [DATA_W-1:0] p3_rdata
);
    // R2
    rd1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd1_en |=> $stable(rd1_data));

    // R3
    p3_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p3_en |=> $stable(p3_rdata));

    // R10
    p3_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p3_en && p3_we) |=> $stable(p3_rdata));

    // R7
    rd1_from_p3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_en && p3_en && p3_we && (p3_addr == rd1_addr))
        |=> (rd1_data == $past(p3_wdata)));

    // R6
    rd1_from_wr2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_en && wr2_en && (wr2_addr == rd1_addr)
         && !(p3_en && p3_we && (p3_addr == rd1_addr)))
        |=> (rd1_data == $past(wr2_data)));

    // R8
    p3_from_wr2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p3_en && !p3_we && wr2_en && (wr2_addr == p3_addr))
        |=> (p3_rdata == $past(wr2_data)));

    // R5
    same_addr_wr_cov: cover property (@(posedge clk) disable iff (!rst_n)
        p3_en && p3_we && wr2_en && (wr2_addr == p3_addr));

endmodule

bind sbox_tri_mem pmem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd1_en   (rd1_en),
    .rd1_addr (rd1_addr),
    .rd1_data (rd1_data),
    .wr2_en   (wr2_en),
    .wr2_addr (wr2_addr),
    .wr2_data (wr2_data),
    .p3_en    (p3_en),
    .p3_we    (p3_we),
    .p3_addr  (p3_addr),
    .p3_wdata (p3_wdata),
    .p3_rdata (p3_rdata)
);

// File: tb/sbox_tri_mem_tb_top.sv
// Bench for sbox_tri_mem. It sweeps every address with expected data
// computed arithmetically and keeps its own model of the table.
module sbox_tri_mem_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd1_en;
    logic [7:0] rd1_addr;
    logic [7:0] rd1_data;
    logic       wr2_en;
    logic [7:0] wr2_addr;
    logic [7:0] wr2_data;
    logic       p3_en;
    logic       p3_we;
    logic [7:0] p3_addr;
    logic [7:0] p3_wdata;
    logic [7:0] p3_rdata;

    int   checks = 0;
    int   fails  = 0;
    logic done   = 1'b0;
    logic [7:0] model [256];

    always #2.5 clk = ~clk;

    sbox_tri_mem #(.ADDR_W(8), .DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr2_en(wr2_en), .wr2_addr(wr2_addr), .wr2_data(wr2_data),
        .p3_en(p3_en), .p3_we(p3_we), .p3_addr(p3_addr),
        .p3_wdata(p3_wdata), .p3_rdata(p3_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Advance one edge and settle just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        rd1_en = 0; wr2_en = 0; p3_en = 0; p3_we = 0;
    endtask

    initial begin
        logic [7:0] hold3;
        logic [7:0] hold1;
        rst_n = 0; idle();
        rd1_addr = 0; wr2_addr = 0; wr2_data = 0; p3_addr = 0; p3_wdata = 0;
        repeat (3) tick();
        chk("R11 rd1 reset", rd1_data, 8'h00);
        chk("R11 p3 reset", p3_rdata, 8'h00);
        rst_n = 1;
        tick();

        // R4: fill both halves with concurrent writes to distinct addresses
        for (int a = 0; a < 128; a++) begin
            wr2_en = 1; wr2_addr = 8'(a); wr2_data = pat(a);
            p3_en = 1; p3_we = 1; p3_addr = 8'(a + 128); p3_wdata = pat(a + 128);
            model[a] = pat(a); model[a + 128] = pat(a + 128);
            tick();
        end
        idle();

        // R1, R2, R3: read every address on both read ports
        for (int a = 0; a < 256; a++) begin
            rd1_en = 1; rd1_addr = 8'(a);
            p3_en = 1; p3_we = 0; p3_addr = 8'(255 - a);
            tick();
            chk("R1 R2 R4 rd1 sweep", rd1_data, model[a]);
            chk("R1 R3 R4 p3 sweep", p3_rdata, model[255 - a]);
        end

        // R2, R3: outputs hold while idle
        hold1 = rd1_data; hold3 = p3_rdata;
        idle(); rd1_addr = 8'd3; p3_addr = 8'd9;
        tick(); tick();
        chk("R2 rd1 hold", rd1_data, hold1);
        chk("R3 p3 hold", p3_rdata, hold3);

        // R6, R8: port-2 write forwarded to both reads of the same address
        for (int a = 0; a < 256; a++) begin
            wr2_en = 1; wr2_addr = 8'(a); wr2_data = ~pat(a);
            rd1_en = 1; rd1_addr = 8'(a);
            p3_en = 1; p3_we = 0; p3_addr = 8'(a);
            model[a] = ~pat(a);
            tick();
            chk("R6 rd1 fwd from port 2", rd1_data, model[a]);
            chk("R8 p3 fwd from port 2", p3_rdata, model[a]);
        end
        idle();

        // R7, R10: port-3 write forwarded to port 1, port-3 output holds
        hold3 = p3_rdata;
        for (int a = 0; a < 256; a++) begin
            p3_en = 1; p3_we = 1; p3_addr = 8'(a); p3_wdata = pat(a) ^ 8'hC3;
            rd1_en = 1; rd1_addr = 8'(a);
            model[a] = pat(a) ^ 8'hC3;
            tick();
            chk("R7 rd1 fwd from port 3", rd1_data, model[a]);
            chk("R10 p3 holds on write", p3_rdata, hold3);
        end
        idle();

        // R1: read back the port-3 writes on port 1
        for (int a = 0; a < 256; a += 5) begin
            rd1_en = 1; rd1_addr = 8'(a);
            tick();
            chk("R1 readback", rd1_data, model[a]);
        end
        idle();

        // R5, R9: both write ports hit one address that port 1 reads
        for (int k = 0; k < 4; k++) begin
            int a;
            a = (k * 85) & 255;
            wr2_en = 1; wr2_addr = 8'(a); wr2_data = 8'(a) ^ 8'h11;
            p3_en = 1; p3_we = 1; p3_addr = 8'(a); p3_wdata = 8'(a) ^ 8'hE8;
            rd1_en = 1; rd1_addr = 8'(a);
            model[a] = 8'(a) ^ 8'hE8;
            tick();
            chk("R9 rd1 gets port 3 data", rd1_data, model[a]);
            idle();
            rd1_en = 1; rd1_addr = 8'(a);
            p3_en = 1; p3_we = 0; p3_addr = 8'(a);
            tick();
            chk("R5 stored port 3 data rd1", rd1_data, model[a]);
            chk("R5 stored port 3 data p3", p3_rdata, model[a]);
            idle();
        end

        // R11: reset clears nonzero outputs
        rd1_en = 1; rd1_addr = 8'd85;
        p3_en = 1; p3_we = 0; p3_addr = 8'd170;
        tick();
        idle();
        rst_n = 0;
        tick();
        chk("R11 rd1 cleared", rd1_data, 8'h00);
        chk("R11 p3 cleared", p3_rdata, 8'h00);
        rst_n = 1;
        tick();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as one failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule